// File: doc/BRIEF.md
# Audio serial clock generator

This block derives the three timing signals of a serial audio port from one kernel clock: a master clock, a bit clock and a frame-sync level. It also gives two one-kernel-cycle strobes: one at the start of every bit period and one at the start of every frame. All logic runs on the kernel clock. The outputs are levels and enables sampled in that domain; they are not separate clock trees.

Four settings control it: a master divider `N`, a direct mode bit, an oversampling bit and a frame-length field `F`. The frame holds `L = F + 1` bit periods.

In ratio mode (direct bit clear), a frame spans 256 master periods, or 512 when the oversampling bit is set. The bit clock is the power-of-two fraction of the master clock that fits `L` bit periods into that frame. In direct mode, the bit clock equals the master clock, and a frame is any `L` from 8 to 256 bit periods.

The settings are sampled only while the enable input is low. Raising enable starts every counter at zero, on a frame start. A configuration that is not legal raises an error flag and keeps every output low.

Top module: `audio_clkgen`

## Requirements
- R1: The master clock period is `N` kernel cycles. A divider value of 0 acts as 1. With 1, the master clock stays high and a new master period starts on every kernel cycle.
- R2: Within each master period, the master clock is high for `ceil(N/2)` kernel cycles and then low for `floor(N/2)` kernel cycles.
- R3: Ratio mode is the direct bit at 0. In this mode a bit period lasts `K = 256*(osr+1)/L` master periods, so a frame lasts `N*K*L` kernel cycles.
- R4: In ratio mode with `K >= 2`, the bit clock is high for exactly `N*K/2` kernel cycles of each bit period. With `K = 1`, or in direct mode, the bit clock follows the master clock and shares its duty cycle.
- R5: Direct mode is the direct bit at 1. In this mode the bit period is `N` kernel cycles and a frame lasts `L*N` kernel cycles, with any `L` from 8 to 256.
- R6: Frame sync is high for the first `ceil(L/2)` bit periods of each frame. The frame-start strobe lasts one kernel cycle, on the first cycle of each frame. Frame sync can rise only on that cycle.
- R7: The bit strobe lasts one kernel cycle, on the first cycle of each bit period, which gives `L` strobes per frame. Every frame-start strobe falls on the same cycle as a bit strobe.
- R8: The error flag is high when `L < 8`, in either mode. In ratio mode it is also high when `L` is not a power of two. While the flag is high, all five timing outputs stay low, even with enable high.
- R9: Setting inputs are sampled only on kernel edges where enable is low. Changes made while enable is high do not affect the outputs.
- R10: The first kernel cycle after enable is sampled high is a frame start: master clock, bit clock, frame sync and both strobes are high. One cycle after enable is sampled low, all outputs are low.
- R11: During reset and after it, while enable is low, every timing output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; settings are sampled while it is low |
| mdiv_i | input | 6 | Master divider value N (0 acts as 1) |
| direct_i | input | 1 | 1: bit clock equals the master clock; 0: ratio mode |
| osr_i | input | 1 | Oversampling select: frame spans 256 (0) or 512 (1) master periods |
| flen_i | input | 8 | Frame length minus one (bit periods per frame minus one) |
| mclk_o | output | 1 | Master clock level |
| bclk_o | output | 1 | Bit clock level |
| fs_o | output | 1 | Frame sync level |
| bclk_rise_o | output | 1 | One-cycle strobe at each bit period start |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |
| cfg_err_o | output | 1 | Sampled configuration is illegal |

## Verification
The frame-start strobe and the bit strobe must fire in the same kernel cycle, on the same cycle as the rise of frame sync. On that cycle the master, ratio and frame counters all wrap together.

Each directed case runs a whole number of frames from the enabling edge. This makes the wraps line up from the first cycle onward, and the cases use odd, even and unit dividers so the coincidence is provoked under every duty pattern. Each cycle that shows a frame-start strobe must also show the bit strobe, frame sync and bit clock high. The spacing between frame starts must equal the frame length the bench computes from the formulas.

// File: rtl/acg_pkg.sv
package acg_pkg;
  parameter int unsigned ACG_DIV_W  = 6;
  parameter int unsigned ACG_FLEN_W = 8;
  parameter int unsigned ACG_MIN_LEN = 8;

  function automatic int unsigned floor_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((v >> i) != 0) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/acg_cfg.sv
module acg_cfg
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W   = ACG_DIV_W,
  parameter int unsigned FLEN_W  = ACG_FLEN_W,
  parameter int unsigned MIN_LEN = ACG_MIN_LEN,
  localparam int unsigned LEN_W  = FLEN_W + 1,
  localparam int unsigned RAT_W  = FLEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  mdiv_i,
  input  logic              direct_i,
  input  logic              osr_i,
  input  logic [FLEN_W-1:0] flen_i,
  output logic [DIV_W-1:0]  n_o,
  output logic [RAT_W-1:0]  k_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              err_o,
  output logic              run_o
);
  logic [DIV_W-1:0]  div_q;
  logic              direct_q;
  logic              osr_q;
  logic [FLEN_W-1:0] flen_q;
  logic              run_q;
  logic [LEN_W-1:0]  len;
  logic              pow2;

  // shadow settings: sampled only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      direct_q <= 1'b0;
      osr_q    <= 1'b0;
      flen_q   <= '0;
    end else if (!en_i) begin
      div_q    <= mdiv_i;
      direct_q <= direct_i;
      osr_q    <= osr_i;
      flen_q   <= flen_i;
    end
  end

  assign len   = LEN_W'(flen_q) + LEN_W'(1);
  assign pow2  = (len & (len - LEN_W'(1))) == '0;
  assign err_o = (len < LEN_W'(MIN_LEN)) || (!direct_q && !pow2);
  assign n_o   = (div_q == '0) ? DIV_W'(1) : div_q;
  assign len_o = len;

  always_comb begin
    int unsigned sh;
    int unsigned kv;
    sh = FLEN_W + 32'(osr_q) - floor_log2(32'(len));
    kv = 32'd1 << sh;
    if (direct_q || err_o) k_o = RAT_W'(1);
    else                   k_o = RAT_W'(kv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i && !err_o;
  end
  assign run_o = run_q;

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable({div_q, direct_q, osr_q, flen_q}));
endmodule

// File: rtl/acg_divider.sv
module acg_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] n_i,
  output logic         wrap_o,
  output logic         zero_o,
  output logic         level_o
);
  logic [W-1:0] cnt;
  logic [W:0]   half;
  logic         last;

  assign last = (cnt == n_i - W'(1));
  assign half = ({1'b0, n_i} + (W+1)'(1)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt <= '0;
    else if (!run_i)  cnt <= '0;
    else if (step_i)  cnt <= last ? '0 : cnt + W'(1);
  end

  assign wrap_o  = run_i && step_i && last;
  assign zero_o  = run_i && (cnt == '0);
  assign level_o = run_i && ({1'b0, cnt} < half);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt < n_i));
  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (zero_o || !run_i));
endmodule

// File: rtl/acg_framer.sv
module acg_framer
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W  = ACG_DIV_W,
  parameter int unsigned FLEN_W = ACG_FLEN_W,
  localparam int unsigned LEN_W = FLEN_W + 1,
  localparam int unsigned RAT_W = FLEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] n_i,
  input  logic [RAT_W-1:0] k_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             fs_o,
  output logic             bclk_rise_o,
  output logic             frame_start_o
);
  logic m_wrap, m_zero, m_lvl;
  logic r_wrap, r_zero, r_lvl;
  logic b_wrap, b_zero, b_lvl;

  acg_divider #(.W(DIV_W)) u_mdiv (
    .clk_i, .rst_ni, .run_i, .step_i(1'b1), .n_i(n_i),
    .wrap_o(m_wrap), .zero_o(m_zero), .level_o(m_lvl)
  );

  // master periods per bit period
  acg_divider #(.W(RAT_W)) u_rdiv (
    .clk_i, .rst_ni, .run_i, .step_i(m_wrap), .n_i(k_i),
    .wrap_o(r_wrap), .zero_o(r_zero), .level_o(r_lvl)
  );

  // bit periods per frame
  acg_divider #(.W(LEN_W)) u_bdiv (
    .clk_i, .rst_ni, .run_i, .step_i(r_wrap), .n_i(len_i),
    .wrap_o(b_wrap), .zero_o(b_zero), .level_o(b_lvl)
  );

  assign mclk_o        = m_lvl;
  assign bclk_o        = (k_i == RAT_W'(1)) ? m_lvl : r_lvl;
  assign bclk_rise_o   = m_zero && r_zero;
  assign frame_start_o = m_zero && r_zero && b_zero;
  assign fs_o          = b_lvl;

  p_frame_on_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (bclk_rise_o && fs_o && bclk_o));
  p_fs_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_o) |-> frame_start_o);
  p_frame_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_wrap |=> (frame_start_o || !run_i));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W   = ACG_DIV_W,
  parameter int unsigned FLEN_W  = ACG_FLEN_W,
  parameter int unsigned MIN_LEN = ACG_MIN_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  mdiv_i,
  input  logic              direct_i,
  input  logic              osr_i,
  input  logic [FLEN_W-1:0] flen_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              bclk_rise_o,
  output logic              frame_start_o,
  output logic              cfg_err_o
);
  localparam int unsigned LEN_W = FLEN_W + 1;
  localparam int unsigned RAT_W = FLEN_W + 2;

  logic [DIV_W-1:0] n;
  logic [RAT_W-1:0] k;
  logic [LEN_W-1:0] len;
  logic             run;

  acg_cfg #(.DIV_W(DIV_W), .FLEN_W(FLEN_W), .MIN_LEN(MIN_LEN)) u_cfg (
    .clk_i, .rst_ni, .en_i, .mdiv_i, .direct_i, .osr_i, .flen_i,
    .n_o(n), .k_o(k), .len_o(len), .err_o(cfg_err_o), .run_o(run)
  );

  acg_framer #(.DIV_W(DIV_W), .FLEN_W(FLEN_W)) u_framer (
    .clk_i, .rst_ni, .run_i(run), .n_i(n), .k_i(k), .len_i(len),
    .mclk_o, .bclk_o, .fs_o, .bclk_rise_o, .frame_start_o
  );

  p_idle_on_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !(mclk_o || bclk_o || fs_o || bclk_rise_o || frame_start_o));
endmodule

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [5:0] mdiv_i = '0;
  logic       direct_i = 1'b0;
  logic       osr_i = 1'b0;
  logic [7:0] flen_i = '0;
  logic mclk_o, bclk_o, fs_o, bclk_rise_o, frame_start_o, cfg_err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  audio_clkgen u_audio_clkgen (
    .clk_i, .rst_ni, .en_i, .mdiv_i, .direct_i, .osr_i, .flen_i,
    .mclk_o, .bclk_o, .fs_o, .bclk_rise_o, .frame_start_o, .cfg_err_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return int'({mclk_o, bclk_o, fs_o, bclk_rise_o, frame_start_o});
  endfunction

  task automatic set_cfg(input int div, input bit dir, input bit osr, input int flen);
    @(negedge clk_i);
    en_i = 1'b0;
    mdiv_i = 6'(div); direct_i = dir; osr_i = osr; flen_i = 8'(flen);
    repeat (2) @(negedge clk_i);
  endtask

  // runs whole frames from the enabling edge and checks counts against formulas
  task automatic run_case(input string req, input int div, input bit dir, input bit osr,
                          input int flen, input int frames, input bit scramble);
    int n, l, k, p, t, hn;
    int c_mh, c_mr, c_bh, c_fs, c_br, c_fr, bad_co, bad_gap, last_fr;
    bit prev_m;
    n = (div == 0) ? 1 : div;
    l = flen + 1;
    k = dir ? 1 : (256 * (osr + 1)) / l;
    p = n * k * l;
    t = frames * p;
    hn = (n + 1) / 2;
    c_mh = 0; c_mr = 0; c_bh = 0; c_fs = 0; c_br = 0; c_fr = 0;
    bad_co = 0; bad_gap = 0; last_fr = -1; prev_m = 1'b0;
    set_cfg(div, dir, osr, flen);
    check(cfg_err_o == 1'b0, {req, " R8 legal cfg no error"}, cfg_err_o, 0);
    check(outs() == 0, {req, " R11 idle before enable"}, outs(), 0);
    en_i = 1'b1;
    for (int i = 0; i < t; i++) begin
      @(negedge clk_i);
      if (scramble && i == 3) begin
        mdiv_i = 6'd7; direct_i = ~dir; osr_i = ~osr; flen_i = 8'd12;
      end
      if (i == 0)
        check(outs() == 5'b11111, {req, " R10 first cycle is frame start"}, outs(), 31);
      if (mclk_o) c_mh++;
      if (mclk_o && !prev_m) c_mr++;
      prev_m = mclk_o;
      if (bclk_o) c_bh++;
      if (fs_o) c_fs++;
      if (bclk_rise_o) c_br++;
      if (frame_start_o) begin
        c_fr++;
        if (!(bclk_rise_o && fs_o && bclk_o)) bad_co++;
        if (last_fr >= 0 && i - last_fr != p) bad_gap++;
        last_fr = i;
      end
    end
    check(c_fr == frames, {req, " R6 frame strobes"}, c_fr, frames);
    check(bad_gap == 0, {req, " R3/R5 frame spacing errors"}, bad_gap, 0);
    check(bad_co == 0, {req, " R7 frame strobe coincidence errors"}, bad_co, 0);
    check(c_br == frames * l, {req, " R7 bit strobes"}, c_br, frames * l);
    check(c_mh == (t / n) * hn, {req, " R2 master high cycles"}, c_mh, (t / n) * hn);
    if (n > 1)
      check(c_mr == t / n, {req, " R1 master periods"}, c_mr, t / n);
    else
      check(c_mh == t, {req, " R1 unit divider master high"}, c_mh, t);
    if (k == 1)
      check(c_bh == frames * l * hn, {req, " R4 bit clock follows master"}, c_bh, frames * l * hn);
    else
      check(c_bh == frames * l * n * k / 2, {req, " R4 bit clock half duty"}, c_bh, frames * l * n * k / 2);
    check(c_fs == frames * ((l + 1) / 2) * n * k, {req, " R6 frame sync high cycles"},
          c_fs, frames * ((l + 1) / 2) * n * k);
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(outs() == 0, {req, " R10 idle after disable"}, outs(), 0);
  endtask

  task automatic err_case(input string req, input bit dir, input int flen);
    int active;
    active = 0;
    set_cfg(2, dir, 1'b0, flen);
    check(cfg_err_o == 1'b1, {req, " R8 error flag"}, cfg_err_o, 1);
    en_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (outs() != 0) active++;
    end
    check(active == 0, {req, " R8 outputs idle on error"}, active, 0);
    en_i = 1'b0;
  endtask

  task automatic reset_case();
    repeat (3) @(negedge clk_i);
    check(outs() == 0, "R11 outputs low in reset", outs(), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(outs() == 0, "R11 outputs low after reset", outs(), 0);
  endtask

  initial begin
    reset_case();
    run_case("A R3", 3, 1'b0, 1'b1, 7, 2, 1'b0);
    run_case("B R4 odd", 3, 1'b0, 1'b0, 255, 2, 1'b0);
    run_case("C R1 zero", 0, 1'b0, 1'b0, 31, 2, 1'b0);
    run_case("D R3 even", 4, 1'b0, 1'b1, 63, 1, 1'b0);
    run_case("E R5", 5, 1'b1, 1'b0, 9, 3, 1'b0);
    run_case("F R5 odd len", 2, 1'b1, 1'b1, 8, 4, 1'b0);
    run_case("G R9 ignore", 2, 1'b0, 1'b0, 15, 2, 1'b1);
    err_case("H R8 not pow2", 1'b0, 11);
    err_case("I R8 short direct", 1'b1, 5);
    err_case("J R8 short ratio", 1'b0, 3);
    run_case("K R5 after err", 1, 1'b1, 1'b0, 255, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule